// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between on-chip logic and an asynchronous parallel NOR flash that uses a two-write command protocol. A client issues one of five requests: program one word, erase one block, erase the whole device, read an identifier word, or return the device to array mode. The block turns each request into a fixed series of bus write and read cycles that carry command codes. It polls the device status register until the device reports ready, then sorts the result into a single outcome code.

Every bus cycle follows the same timing. Chip enable is asserted first. The strobe is held low for a parameterised number of clocks, with setup clocks before it and hold clocks after it. Before a block is erased, the block's lock bit is read, and the block is unlocked if the bit is set. A whole-device erase walks through the blocks in ascending order and stops at the first block that fails. The poll loop has a limit, and a device that never becomes ready produces a timeout outcome that is separate from the device-reported errors.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: In every bus cycle, `fl_we_n` or `fl_oe_n` is low for exactly STROBE_CYC clocks. The two strobes are never low together, and `fl_addr` stays stable while `fl_ce_n` is low.
- R3: Reset request (op 0): a single write of 0x00FF to `req_addr`, then outcome 0 (OK). Read-identifier, program and erase requests start with a 0x00FF write and end with a 0x00FF write.
- R4: Program request (op 2): 0x0010 and then `req_data` are written to `req_addr`. On an OK outcome, 0x0050 is written before the final 0x00FF. On a failure, 0x0050 is not written.
- R5: Read-identifier request (op 1): 0x0090 is written to `req_addr` and one read is made there. The value read is returned on `rsp_data`.
- R6: Block erase (op 3): 0x0090 is written to the block base plus 2 and the lock word is read from that address. If bit 0 is set, 0x0060, 0x00D0 and 0x00FF are written to the block base. Otherwise no unlock writes occur. A block is 2^BLK_AW words.
- R7: Block erase then writes 0x0050, 0x0020 and 0x00D0 to the target address and polls.
- R8: A poll writes 0x0070 and reads once. Polling repeats until bit 7 of the read value is 1, whatever the other bits hold. A device that takes N not-ready reads sees N+1 polls.
- R9: When the device is ready, the outcome `rsp_status` is chosen in this priority order: bit 3 gives 1 (supply), bit 4 gives 2 (program), bit 5 gives 3 (erase, erase requests only), bit 1 gives 4 (locked). Otherwise the outcome is 0. Bit 5 is ignored for a program.
- R10: After POLL_LIMIT consecutive not-ready reads, the outcome is 5 (timeout), followed by the final 0x00FF write.
- R11: Chip erase (op 4) runs the full block-erase sequence on blocks 0 to NUM_BLK-1 at their base addresses. It stops after the first block with a non-OK outcome and reports that outcome.
- R12: A request is taken only while `req_ready` is 1, and `req_ready` drops on the next clock. `rsp_valid` is a single-clock pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 reset, 1 read id, 2 program, 3 erase block, 4 erase chip |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Word to program |
| req_ready | output | 1 | Idle and able to take a request |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_status | output | 3 | Outcome code |
| rsp_data | output | DW | Identifier word read |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Enables the write data driver |
| fl_dq_in | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
Two situations are hard to reach from the ports: a chip erase that fails partway through, and a status word that carries error bits while the device is still busy. The bench drives both through a behavioural flash model. The model returns not-ready for a set number of polls, holds the injected error bits under bit 7 while busy, can fail only one chosen block, and can be made to hang so the poll limit is reached. Locked blocks are preset in the model, so the unlock path runs both alone and inside a chip erase.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_READ_ID    = 3'd1,
        OP_PROGRAM    = 3'd2,
        OP_ERASE_BLK  = 3'd3,
        OP_ERASE_CHIP = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_VPP     = 3'd1,
        RES_PROG    = 3'd2,
        RES_ERASE   = 3'd3,
        RES_LOCKED  = 3'd4,
        RES_TIMEOUT = 3'd5
    } result_e;

    typedef enum logic [4:0] {
        S_IDLE, S_RST0, S_ID_CMD, S_ID_RD, S_PRG_SETUP, S_PRG_DATA,
        S_LK_CMD, S_LK_RD, S_UL_SETUP, S_UL_CONF, S_UL_RST,
        S_CLR_PRE, S_ERS_SETUP, S_ERS_CONF, S_POLL_CMD, S_POLL_RD,
        S_CLR_POST, S_FIN, S_RESP
    } seq_state_e;

    localparam logic [7:0] CMD_ARRAY      = 8'hFF;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_PROG_SETUP = 8'h10;
    localparam logic [7:0] CMD_ERS_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

    localparam int SR_READY   = 7;
    localparam int SR_ERASE   = 5;
    localparam int SR_PROG    = 4;
    localparam int SR_VPP     = 3;
    localparam int SR_LOCK    = 1;
    localparam int LOCK_WORD  = 2;

    function automatic result_e decode_status(input logic [7:0] sr, input logic erase_op);
        if (sr[SR_VPP])                    return RES_VPP;
        else if (sr[SR_PROG])              return RES_PROG;
        else if (erase_op && sr[SR_ERASE]) return RES_ERASE;
        else if (sr[SR_LOCK])              return RES_LOCKED;
        else                               return RES_OK;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    assign done = (ph == PH_HOLD) && (cnt == CW'(HOLD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            rd_q      <= 1'b0;
            rdata     <= '0;
            fl_addr   <= '0;
            fl_dq_out <= '0;
            fl_dq_oe  <= 1'b0;
            fl_ce_n   <= 1'b1;
            fl_we_n   <= 1'b1;
            fl_oe_n   <= 1'b1;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph        <= PH_SETUP;
                    cnt       <= '0;
                    rd_q      <= rd;
                    fl_addr   <= addr;
                    fl_dq_out <= wdata;
                    fl_dq_oe  <= !rd;
                    fl_ce_n   <= 1'b0;
                end
                PH_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
                    ph      <= PH_STROBE;
                    cnt     <= '0;
                    fl_we_n <= rd_q;
                    fl_oe_n <= !rd_q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_STROBE: if (cnt == CW'(STROBE_CYC - 1)) begin
                    ph      <= PH_HOLD;
                    cnt     <= '0;
                    fl_we_n <= 1'b1;
                    fl_oe_n <= 1'b1;
                    if (rd_q) rdata <= fl_dq_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (done) begin
                    ph       <= PH_IDLE;
                    cnt      <= '0;
                    fl_ce_n  <= 1'b1;
                    fl_dq_oe <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R2
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));
    // R2
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));
    // R2
    start_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (ph == PH_IDLE));

endmodule

// File: rtl/nor_poll_ctr.sv
module nor_poll_ctr #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // R10
    no_tick_past_limit_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> !expired);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int BLK_AW     = 4,
    parameter int NUM_BLK    = 4,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int POLL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [2:0]    rsp_status,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

    seq_state_e    state;
    op_e           cur_op;
    result_e       result;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic [DW-1:0] id_data;
    logic [BW-1:0] blk_idx;
    logic          launched;

    logic          bus_start, bus_rd, bus_done, use_data, in_bus;
    logic [7:0]    bus_cmd;
    logic [AW-1:0] bus_addr, blk_base, lock_addr, next_base;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          poll_clear, poll_tick, poll_expired, is_erase, dev_ready;
    result_e       dev_result;

    assign blk_base   = {cur_addr[AW-1:BLK_AW], {BLK_AW{1'b0}}};
    assign lock_addr  = blk_base | AW'(LOCK_WORD);
    assign next_base  = AW'(blk_idx + 1'b1) << BLK_AW;
    assign is_erase   = (cur_op == OP_ERASE_BLK) || (cur_op == OP_ERASE_CHIP);
    assign dev_ready  = bus_rdata[SR_READY];
    assign dev_result = decode_status(bus_rdata[7:0], is_erase);

    always_comb begin
        bus_rd   = 1'b0;
        bus_addr = cur_addr;
        bus_cmd  = CMD_ARRAY;
        use_data = 1'b0;
        case (state)
            S_ID_CMD:    bus_cmd = CMD_IDENT;
            S_ID_RD:     bus_rd  = 1'b1;
            S_PRG_SETUP: bus_cmd = CMD_PROG_SETUP;
            S_PRG_DATA:  use_data = 1'b1;
            S_LK_CMD:    begin bus_addr = lock_addr; bus_cmd = CMD_IDENT; end
            S_LK_RD:     begin bus_addr = lock_addr; bus_rd = 1'b1; end
            S_UL_SETUP:  begin bus_addr = blk_base; bus_cmd = CMD_LOCK_SETUP; end
            S_UL_CONF:   begin bus_addr = blk_base; bus_cmd = CMD_CONFIRM; end
            S_UL_RST:    bus_addr = blk_base;
            S_CLR_PRE:   bus_cmd = CMD_CLR_STATUS;
            S_ERS_SETUP: bus_cmd = CMD_ERS_SETUP;
            S_ERS_CONF:  bus_cmd = CMD_CONFIRM;
            S_POLL_CMD:  bus_cmd = CMD_STATUS;
            S_POLL_RD:   bus_rd  = 1'b1;
            S_CLR_POST:  bus_cmd = CMD_CLR_STATUS;
            default:     ;
        endcase
    end

    assign bus_wdata  = use_data ? cur_data : DW'(bus_cmd);
    assign in_bus     = (state != S_IDLE) && (state != S_RESP);
    assign bus_start  = in_bus && !launched;
    assign poll_clear = bus_done && ((state == S_PRG_DATA) || (state == S_ERS_CONF));
    assign poll_tick  = bus_done && (state == S_POLL_RD) && !dev_ready && !poll_expired;

    assign req_ready  = (state == S_IDLE);
    assign rsp_valid  = (state == S_RESP);
    assign rsp_status = result;
    assign rsp_data   = id_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cur_op   <= OP_RESET;
            result   <= RES_OK;
            cur_addr <= '0;
            cur_data <= '0;
            id_data  <= '0;
            blk_idx  <= '0;
            launched <= 1'b0;
        end else begin
            if (bus_start)     launched <= 1'b1;
            else if (bus_done) launched <= 1'b0;

            if (state == S_IDLE) begin
                if (req_valid) begin
                    cur_op   <= op_e'(req_op);
                    cur_addr <= (op_e'(req_op) == OP_ERASE_CHIP) ? '0 : req_addr;
                    cur_data <= req_data;
                    blk_idx  <= '0;
                    result   <= RES_OK;
                    id_data  <= '0;
                    state    <= S_RST0;
                end
            end else if (state == S_RESP) begin
                state <= S_IDLE;
            end else if (bus_done) begin
                case (state)
                    S_RST0: case (cur_op)
                        OP_RESET:   state <= S_RESP;
                        OP_READ_ID: state <= S_ID_CMD;
                        OP_PROGRAM: state <= S_PRG_SETUP;
                        default:    state <= S_LK_CMD;
                    endcase
                    S_ID_CMD:    state <= S_ID_RD;
                    S_ID_RD:     begin id_data <= bus_rdata; state <= S_FIN; end
                    S_PRG_SETUP: state <= S_PRG_DATA;
                    S_PRG_DATA:  state <= S_POLL_CMD;
                    S_LK_CMD:    state <= S_LK_RD;
                    S_LK_RD:     state <= bus_rdata[0] ? S_UL_SETUP : S_CLR_PRE;
                    S_UL_SETUP:  state <= S_UL_CONF;
                    S_UL_CONF:   state <= S_UL_RST;
                    S_UL_RST:    state <= S_CLR_PRE;
                    S_CLR_PRE:   state <= S_ERS_SETUP;
                    S_ERS_SETUP: state <= S_ERS_CONF;
                    S_ERS_CONF:  state <= S_POLL_CMD;
                    S_POLL_CMD:  state <= S_POLL_RD;
                    S_POLL_RD: begin
                        if (dev_ready) begin
                            result <= dev_result;
                            state  <= (dev_result == RES_OK && cur_op == OP_PROGRAM)
                                      ? S_CLR_POST : S_FIN;
                        end else if (poll_expired) begin
                            result <= RES_TIMEOUT;
                            state  <= S_FIN;
                        end else begin
                            state <= S_POLL_CMD;
                        end
                    end
                    S_CLR_POST: state <= S_FIN;
                    S_FIN: begin
                        if (cur_op == OP_ERASE_CHIP && result == RES_OK &&
                            blk_idx != BW'(NUM_BLK - 1)) begin
                            blk_idx  <= blk_idx + 1'b1;
                            cur_addr <= next_base;
                            state    <= S_RST0;
                        end else begin
                            state <= S_RESP;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    nor_bus_cycle #(
        .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC),
        .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_bus (
        .clk(clk), .rst(rst), .start(bus_start), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .done(bus_done), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    nor_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .clear(poll_clear), .tick(poll_tick), .expired(poll_expired)
    );

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R12
    take_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> !req_ready);
    // R3
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> fl_ce_n);
    // R8
    poll_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_POLL_RD && bus_done && !dev_ready && !poll_expired) |=> state == S_POLL_CMD);

endmodule

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;
    import nor_seq_pkg::*;

    localparam int AW = 16, DW = 16, BLK_AW = 4, NUM_BLK = 4;
    localparam int STROBE = 2, POLL_LIMIT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, rsp_valid, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [2:0]    rsp_status;
    logic [DW-1:0] rsp_data, fl_dq_out, fl_dq_in;
    logic [AW-1:0] fl_addr;

    nor_cmd_seq #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .NUM_BLK(NUM_BLK),
                  .STROBE_CYC(STROBE), .POLL_LIMIT(POLL_LIMIT)) u_nor_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int n_chk = 0, n_fail = 0;

    // ---------------- flash model ----------------
    int          mode;          // 0 array, 1 status, 2 identifier
    int          busy;
    bit          pend_prog, pend_erase, pend_lock, hang;
    logic [15:0] lock_map;
    logic [7:0]  sreg, inj_bits;
    int          inj_blk;
    int          erase_blks[$];
    logic [15:0] prog_addr, prog_data;
    logic [15:0] log_a[$], log_d[$];
    logic        prev_we, prev_oe;
    int          we_w, oe_w;
    localparam int BUSY_POLLS = 3;

    always_comb begin
        case (mode)
            1: fl_dq_in = (hang || busy > 0) ? {8'h00, sreg & 8'h7F} : {8'h00, sreg | 8'h80};
            2: case (fl_addr[3:0])
                   4'd0: fl_dq_in = 16'h0089;
                   4'd1: fl_dq_in = 16'h8817;
                   4'd2: fl_dq_in = {15'b0, lock_map[fl_addr[7:4]]};
                   default: fl_dq_in = 16'h0000;
               endcase
            default: fl_dq_in = 16'hFFFF;
        endcase
    end

    task automatic model_write(input logic [15:0] a, input logic [15:0] d);
        int blk;
        blk = int'(a[7:4]);
        log_a.push_back(a);
        log_d.push_back(d);
        if (pend_prog) begin
            pend_prog = 0; prog_addr = a; prog_data = d;
            if (inj_blk < 0) sreg = sreg | inj_bits;
            busy = BUSY_POLLS; mode = 1;
        end else if (pend_erase) begin
            pend_erase = 0;
            if (d[7:0] == 8'hD0) begin
                erase_blks.push_back(blk);
                if (inj_blk < 0 || inj_blk == blk) sreg = sreg | inj_bits;
                busy = BUSY_POLLS; mode = 1;
            end
        end else if (pend_lock) begin
            pend_lock = 0;
            if (d[7:0] == 8'hD0) lock_map[blk] = 1'b0;
        end else begin
            case (d[7:0])
                8'hFF: mode = 0;
                8'h90: mode = 2;
                8'h70: mode = 1;
                8'h50: sreg = 8'h00;
                8'h10: pend_prog = 1;
                8'h20: pend_erase = 1;
                8'h60: pend_lock = 1;
                default: ;
            endcase
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mode = 0; busy = 0; pend_prog = 0; pend_erase = 0; pend_lock = 0;
            sreg = 0; prev_we = 1; prev_oe = 1; we_w = 0; oe_w = 0;
        end else begin
            if (!fl_we_n && !fl_oe_n) begin
                n_chk++; n_fail++;
                $display("FAIL R2: both strobes low, actual we=%b oe=%b expected one high", fl_we_n, fl_oe_n);
            end
            if (!fl_we_n) we_w++;
            if (!fl_oe_n) oe_w++;
            if (!prev_we && fl_we_n) begin
                n_chk++;
                if (we_w != STROBE) begin
                    n_fail++;
                    $display("FAIL R2: write strobe width actual %0d expected %0d", we_w, STROBE);
                end
                we_w = 0;
                model_write(fl_addr, fl_dq_out);
            end
            if (!prev_oe && fl_oe_n) begin
                n_chk++;
                if (oe_w != STROBE) begin
                    n_fail++;
                    $display("FAIL R2: read strobe width actual %0d expected %0d", oe_w, STROBE);
                end
                oe_w = 0;
                if (mode == 1 && busy > 0 && !hang) busy--;
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [2:0]  st;
        logic [15:0] d;
        bit          chk_d;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic [15:0] ew_a[$], ew_d[$];
    bit prev_rsp = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_rsp && rsp_valid) begin
                n_chk++; n_fail++;
                $display("FAIL R12: rsp_valid held, actual 1 expected 0");
            end
            prev_rsp = rsp_valid;
            if (rsp_valid) begin
                exp_t e;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R12: unexpected response, actual status %0d expected none", rsp_status);
                end else begin
                    e = exp_q.pop_front();
                    if (rsp_status != e.st || (e.chk_d && rsp_data != e.d)) begin
                        n_fail++;
                        $display("FAIL %s: response actual st=%0d d=%h expected st=%0d d=%h",
                                 e.tag, rsp_status, rsp_data, e.st, e.d);
                    end
                end
            end
        end
    end

    task automatic ew(input logic [15:0] a, input logic [15:0] d);
        ew_a.push_back(a);
        ew_d.push_back(d);
    endtask

    task automatic exp_erase(input logic [15:0] a, input bit locked, input bit ok);
        logic [15:0] b;
        b = a & 16'hFFF0;
        ew(a, 16'h00FF); ew(b | 16'h2, 16'h0090);
        if (locked) begin ew(b, 16'h0060); ew(b, 16'h00D0); ew(b, 16'h00FF); end
        ew(a, 16'h0050); ew(a, 16'h0020); ew(a, 16'h00D0); ew(a, 16'h00FF);
        if (!ok) ; // final FF already listed; no extra writes on failure
    endtask

    task automatic exp_prog(input logic [15:0] a, input logic [15:0] d, input bit ok);
        ew(a, 16'h00FF); ew(a, 16'h0010); ew(a, d);
        if (ok) ew(a, 16'h0050);
        ew(a, 16'h00FF);
    endtask

    task automatic set_dev(input logic [7:0] bits, input int blk, input bit hg);
        inj_bits = bits; inj_blk = blk; hang = hg; sreg = 8'h00;
    endtask

    int polls;

    task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d,
                          input logic [2:0] st, input logic [15:0] xd, input bit chk_d,
                          input string tag);
        exp_t e;
        logic [15:0] fa[$], fd[$];
        bit bad;
        while (!req_ready) @(negedge clk);
        log_a.delete(); log_d.delete(); erase_blks.delete();
        e.st = st; e.d = xd; e.chk_d = chk_d; e.tag = tag;
        exp_q.push_back(e);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (req_ready) begin
            n_fail++;
            $display("FAIL R12: req_ready after take actual 1 expected 0");
        end
        while (exp_q.size() != 0) @(negedge clk);
        polls = 0;
        foreach (log_d[i]) begin
            if (log_d[i] == 16'h0070) polls++;
            else begin fa.push_back(log_a[i]); fd.push_back(log_d[i]); end
        end
        bad = (fa.size() != ew_a.size());
        if (!bad) foreach (fa[i]) if (fa[i] != ew_a[i] || fd[i] != ew_d[i]) bad = 1;
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: bus write list actual %0d writes expected %0d", tag, fa.size(), ew_a.size());
            foreach (fa[i]) $display("   got %h <= %h", fa[i], fd[i]);
            foreach (ew_a[i]) $display("   exp %h <= %h", ew_a[i], ew_d[i]);
        end
        ew_a.delete(); ew_d.delete();
    endtask

    task automatic check_int(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        lock_map = 16'h0000; inj_bits = 0; inj_blk = -1; hang = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        n_chk++;
        if (!(req_ready && !rsp_valid && fl_ce_n && fl_we_n && fl_oe_n)) begin
            n_fail++;
            $display("FAIL R1: idle outputs actual rdy=%b rsp=%b ce=%b we=%b oe=%b expected 1 0 1 1 1",
                     req_ready, rsp_valid, fl_ce_n, fl_we_n, fl_oe_n);
        end

        // R3 reset request
        ew(16'h0005, 16'h00FF);
        run_op(3'd0, 16'h0005, 0, 3'd0, 0, 0, "R3");

        // R5 identifier reads
        ew(0, 16'h00FF); ew(0, 16'h0090); ew(0, 16'h00FF);
        run_op(3'd1, 16'h0000, 0, 3'd0, 16'h0089, 1, "R5");
        ew(1, 16'h00FF); ew(1, 16'h0090); ew(1, 16'h00FF);
        run_op(3'd1, 16'h0001, 0, 3'd0, 16'h8817, 1, "R5");

        // R4 program OK, R8 poll count
        set_dev(8'h00, -1, 0);
        exp_prog(16'h0013, 16'h1234, 1);
        run_op(3'd2, 16'h0013, 16'h1234, 3'd0, 0, 0, "R4");
        check_int(int'(prog_data), 16'h1234, "R4", "programmed word");
        check_int(int'(prog_addr), 16'h0013, "R4", "programmed address");
        check_int(polls, BUSY_POLLS + 1, "R8", "status polls");

        // R9 program outcomes
        set_dev(8'h08, -1, 0); exp_prog(16'h0014, 16'hA5A5, 0);
        run_op(3'd2, 16'h0014, 16'hA5A5, 3'd1, 0, 0, "R9");
        set_dev(8'h10, -1, 0); exp_prog(16'h0015, 16'h0F0F, 0);
        run_op(3'd2, 16'h0015, 16'h0F0F, 3'd2, 0, 0, "R9");
        set_dev(8'h02, -1, 0); exp_prog(16'h0016, 16'h1111, 0);
        run_op(3'd2, 16'h0016, 16'h1111, 3'd4, 0, 0, "R9");
        set_dev(8'h18, -1, 0); exp_prog(16'h0017, 16'h2222, 0);
        run_op(3'd2, 16'h0017, 16'h2222, 3'd1, 0, 0, "R9");
        set_dev(8'h20, -1, 0); exp_prog(16'h0018, 16'h3333, 1);
        run_op(3'd2, 16'h0018, 16'h3333, 3'd0, 0, 0, "R9");

        // R6 R7 erase unlocked and locked blocks
        set_dev(8'h00, -1, 0); lock_map = 16'h0008;
        exp_erase(16'h0025, 0, 1);
        run_op(3'd3, 16'h0025, 0, 3'd0, 0, 0, "R7");
        check_int(erase_blks.size() == 1 ? erase_blks[0] : -1, 2, "R7", "erased block");
        exp_erase(16'h0031, 1, 1);
        run_op(3'd3, 16'h0031, 0, 3'd0, 0, 0, "R6");
        check_int(int'(lock_map[3]), 0, "R6", "lock bit after erase");

        // R9 erase outcomes and priority
        set_dev(8'h20, -1, 0); exp_erase(16'h0012, 0, 0);
        run_op(3'd3, 16'h0012, 0, 3'd3, 0, 0, "R9");
        set_dev(8'h22, -1, 0); exp_erase(16'h0012, 0, 0);
        run_op(3'd3, 16'h0012, 0, 3'd3, 0, 0, "R9");
        set_dev(8'h28, -1, 0); exp_erase(16'h0012, 0, 0);
        run_op(3'd3, 16'h0012, 0, 3'd1, 0, 0, "R9");

        // R10 timeout
        set_dev(8'h00, -1, 1); exp_prog(16'h0020, 16'h4444, 0);
        run_op(3'd2, 16'h0020, 16'h4444, 3'd5, 0, 0, "R10");
        check_int(polls, POLL_LIMIT, "R10", "polls before timeout");
        hang = 0;

        // R11 chip erase, all OK with block 1 locked
        set_dev(8'h00, -1, 0); lock_map = 16'h0002;
        for (int b = 0; b < NUM_BLK; b++) exp_erase(16'(b * 16), b == 1, 1);
        run_op(3'd4, 16'h0033, 0, 3'd0, 0, 0, "R11");
        check_int(erase_blks.size(), NUM_BLK, "R11", "blocks erased");
        check_int(int'(lock_map[1]), 0, "R11", "block 1 unlocked");

        // R11 chip erase stopping at block 2
        set_dev(8'h20, 2, 0); lock_map = 16'h0000;
        for (int b = 0; b < 3; b++) exp_erase(16'(b * 16), 0, b != 2);
        run_op(3'd4, 16'h0000, 0, 3'd3, 0, 0, "R11");
        check_int(erase_blks.size(), 3, "R11", "blocks erased before stop");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule